// File: doc/BRIEF.md
# SPI Host Transaction Decoder

This block is the serial front end of a memory-mapped peripheral. A host frames each transaction with an active-low chip select and shifts bytes in most significant bit first (SPI mode 0: data sampled on the rising serial clock edge). The serial lines are sampled by the block's own clock. The two leading bits of the first byte pick the kind of transaction. Prefix `10` opens an addressed write burst. Prefix `01` opens a fixed three-byte command. Prefix `00` is a read. Of the reads, only the all-zero three-byte dummy read has an effect, which is to wake the core. Prefix `11` is reserved and ignored.

Write bursts appear on a one-cycle write port as address, data and strobe. Accepted commands appear on a one-cycle command port as code, parameter and valid. A small power-mode register follows the accepted commands and drives a core clock-enable. The lane-mode input reports whether the link runs in single, dual or quad lane mode. In the multi-lane modes, only the system reset command gets through.

Top module: `spi_host_decoder`

## Requirements
- R1: After reset, pwr_state is 00 (active), core_clk_en is 1, and neither wr_strobe nor cmd_valid pulses until a transaction arrives.
- R2: A frame whose first byte starts with bits 1,0 is a write. The low 6 bits of byte 0, then byte 1, then byte 2 form the 22-bit address, most significant part first. Byte 3 is written to that address.
- R3: Every further byte of a write frame until chip select rises gives one wr_strobe pulse. The address goes up by one per byte and wraps from 3FFFFFh to 000000h.
- R4: A frame starting with bits 0,1 is a command. When its third byte is 00h, cmd_valid pulses once with cmd_code set to the low 6 bits of byte 0 and cmd_param set to byte 1.
- R5: A command whose third byte is not 00h is discarded. So is a command frame that ends before its third byte completes. Neither gives any cmd_valid pulse or change of power state.
- R6: lane_mode encodes 00 single, 01 dual, 10 quad (11 is treated as multi-lane). In any mode other than 00, every command except system reset (code 28h) is discarded. Write decoding does not depend on lane_mode.
- R7: A frame whose first three bytes are all 00h is taken as the wake-up command. It gives cmd_valid with code 00h and parameter 00h, subject to R6. Any other read frame (prefix 00) gives no pulse.
- R8: The accepted codes set pwr_state as follows: 00h to active (00), 01h to standby (01), 02h to sleep (10), 10h to power-down (11), and system reset 28h to active.
- R9: pwr_state holds when no command is accepted. An accepted command with any other code leaves it unchanged.
- R10: core_clk_en is 1 only when pwr_state is active, and 0 in standby, sleep and power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| lane_mode | input | 2 | Link lane mode: 00 single, 01 dual, 10 quad |
| wr_addr | output | 22 | Address of the current write byte |
| wr_data | output | 8 | Write data byte |
| wr_strobe | output | 1 | One-cycle pulse marking a write |
| cmd_code | output | 6 | Code of the accepted command |
| cmd_param | output | 8 | Parameter byte of the accepted command |
| cmd_valid | output | 1 | One-cycle pulse marking an accepted command |
| pwr_state | output | 2 | Power mode: 00 active, 01 standby, 10 sleep, 11 power-down |
| core_clk_en | output | 1 | Core clock enable, high only in active mode |

## Verification
The hardest case to reach from the ports is the address wrap at the top of the 22-bit space inside one burst. Random addresses almost never land within a few bytes of 3FFFFFh, so a directed burst starts at 3FFFFEh and runs across the boundary. The second hard case is how lane gating combines with the power state. A non-reset command sent in quad mode must leave a known sleep or standby state untouched, and system reset must still get through. Directed frames set up these combinations. Random frames then mix all prefixes, lane modes, truncated frames and non-zero third bytes, and check each one against a bench model of the power state.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_SLEEP   = 2'd2,
    PWR_DOWN    = 2'd3
  } pwr_t;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_CMD   = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_t;
endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              frame_idle,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q, sck_p, cs_q, mosi_q;
  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
  logic [BYTE_W-2:0] shreg, shreg_n;
  logic              vld_n;
  logic [BYTE_W-1:0] data_n;
  logic              sck_rise;

  assign sck_rise   = sck_q & ~sck_p & ~cs_q;
  assign frame_idle = cs_q;

  always_comb begin
    bit_cnt_n = bit_cnt;
    shreg_n   = shreg;
    vld_n     = 1'b0;
    data_n    = byte_data;
    if (cs_q) begin
      bit_cnt_n = '0;
    end else if (sck_rise) begin
      shreg_n   = {shreg[BYTE_W-3:0], mosi_q};
      bit_cnt_n = bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
        vld_n  = 1'b1;
        data_n = {shreg, mosi_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      sck_p     <= 1'b0;
      cs_q      <= 1'b1;
      mosi_q    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      sck_q     <= sck;
      sck_p     <= sck_q;
      cs_q      <= cs_n;
      mosi_q    <= mosi;
      bit_cnt   <= bit_cnt_n;
      shreg     <= shreg_n;
      byte_vld  <= vld_n;
      if (vld_n) byte_data <= data_n;
    end
  end

  // A byte takes many clocks, so completions are never back to back (feeds R2, R4).
  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_dec_pkg::*;
#(
  parameter int              ADDR_W   = 22,
  parameter int              CODE_W   = 6,
  parameter logic [CODE_W-1:0] RST_CODE = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_idle,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [1:0]        lane_mode,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_strobe,
  output logic [CODE_W-1:0] cmd_code,
  output logic [BYTE_W-1:0] cmd_param,
  output logic              cmd_valid
);
  localparam int HI_W = ADDR_W - 2 * BYTE_W;

  logic [1:0]        idx, idx_n;
  logic [BYTE_W-1:0] hdr0, hdr0_n, hdr1, hdr1_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              wr_stb_n, cmd_vld_n;
  logic [ADDR_W-1:0] wr_addr_n;
  logic [BYTE_W-1:0] wr_data_n, cmd_param_n;
  logic [CODE_W-1:0] cmd_code_n;
  kind_t             kind;
  logic              single_lane;

  assign kind        = kind_t'(hdr0[BYTE_W-1:BYTE_W-2]);
  assign single_lane = (lane_mode == 2'b00);

  always_comb begin
    idx_n       = idx;
    hdr0_n      = hdr0;
    hdr1_n      = hdr1;
    addr_n      = addr;
    wr_stb_n    = 1'b0;
    wr_addr_n   = wr_addr;
    wr_data_n   = wr_data;
    cmd_vld_n   = 1'b0;
    cmd_code_n  = cmd_code;
    cmd_param_n = cmd_param;
    if (frame_idle) begin
      idx_n = 2'd0;
    end else if (byte_vld) begin
      case (idx)
        2'd0: begin
          hdr0_n = byte_data;
          idx_n  = 2'd1;
        end
        2'd1: begin
          hdr1_n = byte_data;
          idx_n  = 2'd2;
        end
        2'd2: begin
          idx_n = 2'd3;
          if (kind == KIND_WRITE) begin
            addr_n = {hdr0[HI_W-1:0], hdr1, byte_data};
          end else if (kind == KIND_CMD && byte_data == '0 &&
                       (single_lane || hdr0[CODE_W-1:0] == RST_CODE)) begin
            cmd_vld_n   = 1'b1;
            cmd_code_n  = hdr0[CODE_W-1:0];
            cmd_param_n = hdr1;
          end else if (kind == KIND_READ && hdr0 == '0 && hdr1 == '0 &&
                       byte_data == '0 && single_lane) begin
            cmd_vld_n   = 1'b1;
            cmd_code_n  = '0;
            cmd_param_n = '0;
          end
        end
        default: begin
          if (kind == KIND_WRITE) begin
            wr_stb_n  = 1'b1;
            wr_addr_n = addr;
            wr_data_n = byte_data;
            addr_n    = addr + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= 2'd0;
      hdr0      <= '0;
      hdr1      <= '0;
      addr      <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_param <= '0;
    end else begin
      idx       <= idx_n;
      hdr0      <= hdr0_n;
      hdr1      <= hdr1_n;
      addr      <= addr_n;
      wr_strobe <= wr_stb_n;
      wr_addr   <= wr_addr_n;
      wr_data   <= wr_data_n;
      cmd_valid <= cmd_vld_n;
      cmd_code  <= cmd_code_n;
      cmd_param <= cmd_param_n;
    end
  end

  // Next burst location sits one above the address just written, modulo 2^ADDR_W.
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> addr == wr_addr + 1'b1);

  // In a multi-lane mode only system reset reaches the command port.
  assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(lane_mode) == 2'b00 || cmd_code == RST_CODE));

  // A write pulse and a command pulse never coincide.
  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && cmd_valid));
endmodule

// File: rtl/spi_pwr_ctl.sv
module spi_pwr_ctl
  import spi_dec_pkg::*;
#(
  parameter int                CODE_W     = 6,
  parameter logic [CODE_W-1:0] STBY_CODE  = 6'h01,
  parameter logic [CODE_W-1:0] SLEEP_CODE = 6'h02,
  parameter logic [CODE_W-1:0] PDN_CODE   = 6'h10,
  parameter logic [CODE_W-1:0] RST_CODE   = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output logic [1:0]        pwr_state,
  output logic              core_clk_en
);
  pwr_t state, state_n;

  always_comb begin
    state_n = state;
    if (cmd_valid) begin
      if (cmd_code == '0 || cmd_code == RST_CODE) state_n = PWR_ACTIVE;
      else if (cmd_code == STBY_CODE)             state_n = PWR_STANDBY;
      else if (cmd_code == SLEEP_CODE)            state_n = PWR_SLEEP;
      else if (cmd_code == PDN_CODE)              state_n = PWR_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PWR_ACTIVE;
      core_clk_en <= 1'b1;
    end else if (cmd_valid) begin
      state       <= state_n;
      core_clk_en <= (state_n == PWR_ACTIVE);
    end
  end

  assign pwr_state = state;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(pwr_state));

  assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == STBY_CODE) |=> pwr_state == PWR_STANDBY);

  assert_clk_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en == (pwr_state == PWR_ACTIVE));
endmodule

// File: rtl/spi_host_decoder.sv
module spi_host_decoder
  import spi_dec_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter int                CODE_W     = 6,
  parameter logic [CODE_W-1:0] STBY_CODE  = 6'h01,
  parameter logic [CODE_W-1:0] SLEEP_CODE = 6'h02,
  parameter logic [CODE_W-1:0] PDN_CODE   = 6'h10,
  parameter logic [CODE_W-1:0] RST_CODE   = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [1:0]        lane_mode,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_strobe,
  output logic [CODE_W-1:0] cmd_code,
  output logic [7:0]        cmd_param,
  output logic              cmd_valid,
  output logic [1:0]        pwr_state,
  output logic              core_clk_en
);
  logic              frame_idle, byte_vld;
  logic [BYTE_W-1:0] byte_data;

  spi_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame_idle(frame_idle), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  spi_frame_ctl #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_idle(frame_idle), .byte_vld(byte_vld),
    .byte_data(byte_data), .lane_mode(lane_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strobe(wr_strobe),
    .cmd_code(cmd_code), .cmd_param(cmd_param), .cmd_valid(cmd_valid)
  );

  spi_pwr_ctl #(.CODE_W(CODE_W), .STBY_CODE(STBY_CODE), .SLEEP_CODE(SLEEP_CODE),
                .PDN_CODE(PDN_CODE), .RST_CODE(RST_CODE)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pwr_state(pwr_state), .core_clk_en(core_clk_en)
  );
endmodule

// File: tb/sim_spi_host_decoder.sv
module sim_spi_host_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [1:0]  lane = 2'b00;
  logic [21:0] wr_addr;
  logic [7:0]  wr_data, cmd_param;
  logic        wr_strobe, cmd_valid, core_clk_en;
  logic [5:0]  cmd_code;
  logic [1:0]  pwr_state;

  always #2 clk = ~clk;

  spi_host_decoder u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .lane_mode(lane), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strobe(wr_strobe),
    .cmd_code(cmd_code), .cmd_param(cmd_param), .cmd_valid(cmd_valid),
    .pwr_state(pwr_state), .core_clk_en(core_clk_en)
  );

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_cmd = 0;
  logic [21:0] ev_wa [0:15];
  logic [7:0]  ev_wd [0:15];
  logic [5:0]  ev_code;
  logic [7:0]  ev_param;
  logic [7:0]  tx [0:7];
  int          tx_len;
  logic [1:0]  exp_pwr = 2'b00;
  bit          done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && wr_strobe) begin
      if (n_wr < 16) begin ev_wa[n_wr] = wr_addr; ev_wd[n_wr] = wr_data; end
      n_wr++;
    end
    if (rst_n && cmd_valid) begin
      n_cmd++; ev_code = cmd_code; ev_param = cmd_param;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pwr_model(input logic [1:0] s, input logic [5:0] c);
    case (c)
      6'h00, 6'h28: return 2'b00;
      6'h01: return 2'b01;
      6'h02: return 2'b10;
      6'h10: return 2'b11;
      default: return s;
    endcase
  endfunction

  task automatic send_frame();
    n_wr = 0; n_cmd = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < tx_len; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx[b][i];
        repeat (4) @(negedge clk); sck = 1'b1;
        repeat (4) @(negedge clk); sck = 1'b0;
      end
    end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // Write burst model: addresses step by one modulo 2^22 (R2, R3).
  task automatic do_write(input logic [21:0] a, input int nd);
    logic [7:0] d [0:7];
    tx[0] = {2'b10, a[21:16]}; tx[1] = a[15:8]; tx[2] = a[7:0];
    for (int i = 0; i < nd; i++) begin d[i] = 8'($urandom); tx[3+i] = d[i]; end
    tx_len = 3 + nd;
    send_frame();
    chk(n_wr == nd, "R2 write count", n_wr, nd);
    for (int i = 0; i < nd && i < n_wr; i++) begin
      chk(ev_wa[i] == 22'(a + 22'(i)), "R3 burst address", int'(ev_wa[i]), int'(22'(a + 22'(i))));
      chk(ev_wd[i] == d[i], "R2 write data", ev_wd[i], d[i]);
    end
    chk(n_cmd == 0, "R2 no command from write", n_cmd, 0);
  endtask

  // Three-byte (or truncated) command or read frame against the model (R4-R9).
  task automatic do_cmd(input logic [7:0] b0, b1, b2, input int len, input string req);
    bit acc;
    logic [5:0] c;
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx_len = len;
    c = (b0[7:6] == 2'b01) ? b0[5:0] : 6'h00;
    acc = (len == 3) &&
          ((b0[7:6] == 2'b01 && b2 == 8'h00) || (b0 == 0 && b1 == 0 && b2 == 0)) &&
          (lane == 2'b00 || (b0[7:6] == 2'b01 && b0[5:0] == 6'h28));
    send_frame();
    chk(n_cmd == (acc ? 1 : 0), req, n_cmd, acc ? 1 : 0);
    if (acc && n_cmd == 1) begin
      chk(ev_code == c, "R4 command code", ev_code, c);
      chk(ev_param == (b0[7:6] == 2'b01 ? b1 : 8'h00), "R4 command param", ev_param, b1);
      exp_pwr = pwr_model(exp_pwr, c);
    end
    chk(n_wr == 0, "R4 no write from command", n_wr, 0);
    chk(pwr_state == exp_pwr, "R8 R9 power state", pwr_state, exp_pwr);
    chk(core_clk_en == (exp_pwr == 2'b00), "R10 clock enable", core_clk_en, exp_pwr == 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(pwr_state == 2'b00, "R1 reset power state", pwr_state, 0);
    chk(core_clk_en == 1'b1, "R1 reset clock enable", core_clk_en, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_wr == 0 && n_cmd == 0, "R1 no pulses after reset", n_wr + n_cmd, 0);

    do_write(22'h3FFFFE, 4);                          // R3 wrap at top of space
    do_write(22'h12A5C3, 3);                          // R2 address assembly
    do_cmd(8'h41, 8'h00, 8'h00, 3, "R8 standby accepted");
    do_cmd(8'h00, 8'h00, 8'h00, 3, "R7 dummy read wakes");
    do_cmd(8'h42, 8'h00, 8'h00, 3, "R8 sleep accepted");
    lane = 2'b10;
    do_cmd(8'h50, 8'h00, 8'h00, 3, "R6 quad drops power-down");
    do_cmd(8'h00, 8'h00, 8'h00, 3, "R6 quad drops wake-up");
    do_write(22'h000010, 2);                          // R6 writes unaffected
    do_cmd(8'h68, 8'h00, 8'h00, 3, "R6 quad passes system reset");
    lane = 2'b01;
    do_cmd(8'h41, 8'h00, 8'h00, 3, "R6 dual drops standby");
    lane = 2'b00;
    do_cmd(8'h41, 8'h00, 8'h05, 3, "R5 non-zero third byte dropped");
    do_cmd(8'h41, 8'h00, 8'h00, 2, "R5 truncated command dropped");
    do_cmd(8'h00, 8'h01, 8'h00, 3, "R7 other read ignored");
    do_cmd(8'h50, 8'h00, 8'h00, 3, "R8 power-down accepted");
    do_cmd(8'h7F, 8'hA5, 8'h00, 3, "R9 unknown code no state change");
    do_cmd(8'h40, 8'h00, 8'h00, 3, "R8 code 00h to active");

    for (int t = 0; t < 40; t++) begin
      int k;
      logic [7:0] b0, b1, b2;
      logic [5:0] codes [0:5];
      codes[0] = 6'h00; codes[1] = 6'h01; codes[2] = 6'h02;
      codes[3] = 6'h10; codes[4] = 6'h28; codes[5] = 6'($urandom);
      lane = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      k = $urandom_range(0, 5);
      if (k == 0) begin
        do_write(22'($urandom), $urandom_range(1, 5));
      end else begin
        b0 = (k == 5) ? 8'($urandom) : {2'b01, codes[$urandom_range(0, 5)]};
        if (k == 4) b0 = 8'h00;
        b1 = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom);
        b2 = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
        if (b0[7:6] == 2'b10) b0[7:6] = 2'b11;   // keep writes in the write task
        do_cmd(b0, b1, b2, ($urandom_range(0, 4) == 0) ? 2 : 3, "R5 R6 R7 random frame");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule